// File: doc/BRIEF.md
# Tuning Synthesizer Divider and Phase Detector

This block is the digital heart of a tuner's frequency synthesizer. A slow crystal time base (75 kHz, delivered as a one-cycle strobe `xtal_en` in the fast clock domain) is divided down to one of six comparison rates. The local-oscillator input, also delivered as a strobe `lo_en`, is divided by a programmable ratio. In the AM band this is a plain down counter. In the FM band it is a halving stage followed by a pulse-swallow pair: a 16/17 dual-modulus prescaler steered by a swallow count and a main count.

A phase/frequency detector compares the two divided streams and drives a three-state pump output, given as a data bit `pump_hi` and an enable `pump_oe`. A selectable dead band hides the shortest pump pulses. The pump is forced to high impedance whenever the loop is stopped, halted, in backup or in reset. Any of those states also restarts all the counters.

Top module: `tune_synth`

## Requirements
- R1: While `rst_n` is low or any of `halt`, `backup`, `pll_stop` is high, `pump_oe` and `pump_hi` are 0 in the same cycle. The first clock edge in that state reloads every counter and clears the detector.
- R2: The reference pulse occurs once every D strobes of `xtal_en`. D depends on `ref_sel`: 0→75, 1→25, 2→15, 3→12, 4→6, 5→3, and 6 or 7 give 75. These match comparison rates of 1, 3, 5, 6.25, 12.5 and 25 kHz from a 75 kHz crystal.
- R3: With `band` = 2'b11 (AM), a divider pulse occurs once every N strobes of `lo_en`, where N = `n_word` and N ≥ 1.
- R4: With any other `band` value (FM), a divider pulse occurs once every 2·N strobes of `lo_en`. The strobes are halved first, then divided by the 16/17 swallow pair with M = `n_word[15:4]`, A = `n_word[3:0]` and N = 16·M + A. The user keeps M ≥ 1 and A ≤ M.
- R5: When a divider pulse arrives before a reference pulse, the pump drives high (`pump_oe`=1, `pump_hi`=1). When the reference pulse arrives first, the pump drives low (`pump_oe`=1, `pump_hi`=0). The pulse that arrives second returns the pump to high impedance.
- R6: A divider pulse and a reference pulse in the same cycle cancel each other, and the pump stays at high impedance.
- R7: With `dz_mode`=0, the first cycle of each pump pulse is hidden. With `dz_mode`=1, the first two cycles are hidden. A pulse held internally for L cycles therefore appears for max(0, L−1) or max(0, L−2) cycles.
- R8: A new `n_word` takes effect only at the divider's terminal count. Changing it mid-count does not alter the count already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_en | input | 1 | One strobe per crystal period |
| lo_en | input | 1 | One strobe per local-oscillator period |
| ref_sel | input | 3 | Reference rate select |
| band | input | 2 | 2'b11 selects AM, other values select FM |
| n_word | input | NW | Divide ratio N |
| dz_mode | input | 1 | Dead-band width select |
| pll_stop | input | 1 | Stop the loop |
| halt | input | 1 | Halt state |
| backup | input | 1 | Backup state |
| pump_hi | output | 1 | Pump drive level |
| pump_oe | output | 1 | Pump drive enable, 0 means high impedance |

## Verification
The bench measures each divide ratio by counting strobes until the pump turns on. It does this for every reference code, including the codes that fall back to 75. It also covers random AM ratios and random FM swallow splits, including A = 0 and A = M, so a prescaler stuck at one modulus or a miscounted swallow shows up as a wrong strobe count.

Pump pulses of lengths 1 to 4 cycles are built in both directions and in both dead-band modes. An off-by-one in the hiding logic shows up as an extra or missing visible cycle. Coincident pulses are run for many periods to catch a detector that leaks a one-cycle pulse. A mid-count change of `n_word` exposes a divider that latches N immediately.

// File: rtl/tune_synth.sv
module tune_synth #(
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xtal_en,
  input  logic          lo_en,
  input  logic [2:0]    ref_sel,
  input  logic [1:0]    band,
  input  logic [NW-1:0] n_word,
  input  logic          dz_mode,
  input  logic          pll_stop,
  input  logic          halt,
  input  logic          backup,
  output logic          pump_hi,
  output logic          pump_oe
);
  localparam int MW = NW - 4;

  function automatic logic [6:0] ref_ratio(input logic [2:0] s);
    case (s)
      3'd1: ref_ratio = 7'd25;
      3'd2: ref_ratio = 7'd15;
      3'd3: ref_ratio = 7'd12;
      3'd4: ref_ratio = 7'd6;
      3'd5: ref_ratio = 7'd3;
      default: ref_ratio = 7'd75;
    endcase
  endfunction

  logic active, am;
  assign active = rst_n & ~pll_stop & ~halt & ~backup;
  assign am = (band == 2'b11);

  logic [6:0] rc;
  logic ref_p;
  assign ref_p = active & xtal_en & (rc == 7'd1);

  always_ff @(posedge clk) begin
    if (!active) rc <= ref_ratio(ref_sel);
    else if (xtal_en) rc <= (rc == 7'd1) ? ref_ratio(ref_sel) : rc - 7'd1;
  end

  logic [NW-1:0] dc;
  logic [MW-1:0] m;
  logic [3:0] a;
  logic [4:0] pc;
  logic t, pre_tick, pm, div_p;
  assign pre_tick = lo_en & t;
  assign pm = pre_tick & (pc == 5'd1);
  assign div_p = active & (am ? (lo_en & (dc == NW'(1))) : (pm & (m == MW'(1))));

  always_ff @(posedge clk) begin
    if (!active) begin
      dc <= n_word;
      t  <= 1'b0;
      m  <= n_word[NW-1:4];
      a  <= n_word[3:0];
      pc <= (n_word[3:0] != 4'd0) ? 5'd17 : 5'd16;
    end else if (am) begin
      if (lo_en) dc <= (dc == NW'(1)) ? n_word : dc - NW'(1);
    end else begin
      if (lo_en) t <= ~t;
      if (pm) begin
        if (m == MW'(1)) begin
          m  <= n_word[NW-1:4];
          a  <= n_word[3:0];
          pc <= (n_word[3:0] != 4'd0) ? 5'd17 : 5'd16;
        end else begin
          m  <= m - MW'(1);
          a  <= (a == 4'd0) ? 4'd0 : a - 4'd1;
          pc <= (a > 4'd1) ? 5'd17 : 5'd16;
        end
      end else if (pre_tick) begin
        pc <= pc - 5'd1;
      end
    end
  end

  logic fast, slow, f_n, s_n, both;
  logic [1:0] w;
  assign f_n = fast | div_p;
  assign s_n = slow | ref_p;
  assign both = f_n & s_n;

  always_ff @(posedge clk) begin
    if (!active) begin
      fast <= 1'b0;
      slow <= 1'b0;
      w    <= 2'd0;
    end else begin
      fast <= f_n & ~both;
      slow <= s_n & ~both;
      if (both || !(f_n | s_n) || !(fast | slow)) w <= 2'd0;
      else if (w != 2'd3) w <= w + 2'd1;
    end
  end

  assign pump_oe = active & (fast | slow) & (w >= (dz_mode ? 2'd2 : 2'd1));
  assign pump_hi = pump_oe & fast;
endmodule

// File: rtl/tune_synth_chk.sv
module tune_synth_chk (
  input logic clk,
  input logic rst_n,
  input logic halt,
  input logic backup,
  input logic pll_stop,
  input logic dz_mode,
  input logic fast,
  input logic slow,
  input logic pump_hi,
  input logic pump_oe
);
  assert_off_states_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (halt | backup | pll_stop) |-> (!pump_oe && !pump_hi));

  assert_hi_needs_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pump_hi |-> pump_oe);

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast && slow));

  assert_deadband_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pump_oe |-> $past(fast | slow));

  assert_deadband_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_oe && dz_mode) |-> ($past(fast | slow) && $past(fast | slow, 2)));
endmodule

bind tune_synth tune_synth_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .backup(backup), .pll_stop(pll_stop),
  .dz_mode(dz_mode), .fast(fast), .slow(slow), .pump_hi(pump_hi), .pump_oe(pump_oe)
);

// File: tb/sim_tune_synth.sv
module sim_tune_synth;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, xtal_en = 0, lo_en = 0, dz_mode = 0;
  logic pll_stop = 0, halt = 0, backup = 0;
  logic [2:0] ref_sel = 0;
  logic [1:0] band = 2'b11;
  logic [15:0] n_word = 16'd1;
  logic pump_hi, pump_oe;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  tune_synth u0 (.clk, .rst_n, .xtal_en, .lo_en, .ref_sel, .band, .n_word,
                 .dz_mode, .pll_stop, .halt, .backup, .pump_hi, .pump_oe);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ref(input int s);
    case (s)
      1: return 25; 2: return 15; 3: return 12; 4: return 6; 5: return 3;
      default: return 75;
    endcase
  endfunction

  function automatic int exp_lo(input logic [1:0] b, input int n);
    return (b == 2'b11) ? n : 2 * n;
  endfunction

  task automatic cyc(input logic x, input logic l);
    xtal_en = x; lo_en = l;
    @(negedge clk);
    xtal_en = 0; lo_en = 0;
  endtask

  task automatic restart();
    pll_stop = 1; cyc(0, 0); pll_stop = 0;
  endtask

  task automatic meas(input bit use_x, input int limit, output int k, output logic hi);
    k = 0; hi = 0;
    while (k < limit) begin
      if (use_x) cyc(1, 0); else cyc(0, 1);
      k++;
      cyc(0, 0); cyc(0, 0);
      if (pump_oe) begin hi = pump_hi; break; end
    end
  endtask

  task automatic deadband(input logic mode, input int len, input bit up);
    int seen = 0, wrong = 0, want;
    dz_mode = mode; ref_sel = 5; band = 2'b11; n_word = 16'd1;
    restart();
    cyc(1, 0); cyc(1, 0);
    if (up) cyc(0, 1); else cyc(1, 0);
    if (pump_oe) begin seen++; if (pump_hi != up) wrong++; end
    for (int i = 1; i < len; i++) begin
      cyc(0, 0);
      if (pump_oe) begin seen++; if (pump_hi != up) wrong++; end
    end
    if (up) cyc(1, 0); else cyc(0, 1);
    if (pump_oe) seen++;
    want = (len > (mode ? 2 : 1)) ? len - (mode ? 2 : 1) : 0;
    chk(seen == want, "R7 visible pump cycles", seen, want);
    chk(wrong == 0, "R5 pump level during pulse", wrong, 0);
  endtask

  initial begin
    int k; logic hi; int n, mm, aa, seen;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(pump_oe == 0 && pump_hi == 0, "R1 reset state", pump_oe, 0);
    rst_n = 1;
    @(negedge clk);

    for (int s = 0; s < 8; s++) begin
      ref_sel = 3'(s); restart();
      meas(1, 100, k, hi);
      chk(k == exp_ref(s), "R2 reference ratio", k, exp_ref(s));
      chk(hi == 0, "R5 reference first drives low", hi, 0);
    end

    band = 2'b11; n_word = 16'd7; restart();
    meas(0, 100, k, hi);
    chk(k == 7, "R3 AM ratio 7", k, 7);
    chk(hi == 1, "R5 divider first drives high", hi, 1);

    band = 2'b00; n_word = 16'd16; restart();
    meas(0, 200, k, hi);
    chk(k == 32, "R4 FM M=1 A=0", k, 32);
    n_word = 16'd34; restart();
    meas(0, 200, k, hi);
    chk(k == 68, "R4 FM M=2 A=2", k, 68);

    for (int i = 0; i < 16; i++) begin
      band = ($urandom % 2) ? 2'b11 : 2'(($urandom % 3));
      dz_mode = 1'($urandom % 2);
      if (band == 2'b11) n = 1 + $urandom % 200;
      else begin
        mm = 1 + $urandom % 12;
        aa = $urandom % (mm + 1);
        if (aa > 15) aa = 15;
        n = 16 * mm + aa;
      end
      n_word = 16'(n); restart();
      meas(0, exp_lo(band, n) + 5, k, hi);
      chk(k == exp_lo(band, n), band == 2'b11 ? "R3 random AM ratio" : "R4 random FM ratio",
          k, exp_lo(band, n));
    end
    dz_mode = 0;

    band = 2'b11; n_word = 16'd5; ref_sel = 5; restart();
    cyc(0, 1); cyc(0, 1);
    n_word = 16'd9;
    meas(0, 20, k, hi);
    chk(k == 3, "R8 count in progress keeps old N", k, 3);
    cyc(1, 0); cyc(1, 0); cyc(1, 0);
    chk(pump_oe == 0, "R5 second pulse returns to high impedance", pump_oe, 0);
    meas(0, 20, k, hi);
    chk(k == 9, "R8 new N after terminal count", k, 9);

    ref_sel = 5; band = 2'b11; n_word = 16'd3; restart();
    seen = 0;
    for (int i = 0; i < 30; i++) begin cyc(1, 1); if (pump_oe) seen++; end
    chk(seen == 0, "R6 coincident pulses stay high impedance", seen, 0);

    for (int s = 0; s < 3; s++) begin
      n_word = 16'd1; band = 2'b11; restart();
      cyc(0, 1); cyc(0, 0);
      chk(pump_oe == 1, "R1 pump active before stop", pump_oe, 1);
      if (s == 0) halt = 1; else if (s == 1) backup = 1; else pll_stop = 1;
      #1;
      chk(pump_oe == 0 && pump_hi == 0, "R1 stop state forces high impedance", pump_oe, 0);
      cyc(0, 0);
      halt = 0; backup = 0; pll_stop = 0;
      #1;
      chk(pump_oe == 0, "R1 detector cleared by stop state", pump_oe, 0);
      @(negedge clk);
    end

    for (int md = 0; md < 2; md++)
      for (int len = 1; len <= 4; len++) begin
        deadband(1'(md), len, 1);
        deadband(1'(md), len, 0);
      end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule